// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Register

This block is the arithmetic and logic unit of a small accumulator-based microcontroller core. Each cycle it takes the accumulator byte, a second operand (a memory byte or an immediate) and a 4-bit operation code. It produces the 8-bit result combinationally in the same cycle. It also holds the three status flags: carry (C), half carry (DC) and zero (Z). The flags update on the clock edge, but only in cycles where `op_valid_i` is high.

Each operation class writes its own fixed subset of the flags and leaves the others alone. For that reason the block drives the next value and a write enable for each flag. The add-with-carry, subtract-with-borrow and rotate operations read the carry from the block's own flag register. Subtraction keeps C as an inverted borrow, so C=1 means no borrow occurred. Instruction decode, the register file and memory access sit outside this block.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i` are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 rotate right through carry, 8 rotate left through carry, 9 nibble swap, 10 load memory byte, 11 load immediate, 12 store accumulator. Codes 13 to 15 give `result_o` = accumulator and write no flag.
- R2: Add gives accumulator + operand modulo 256, and C is the carry out of bit 7. Add-with-carry also adds the stored C.
- R3: Subtract gives accumulator − operand modulo 256, with C=0 when a borrow occurs and C=1 otherwise. Subtract-with-borrow also subtracts the inverse of the stored C.
- R4: DC is the carry out of bit 3 for additions, and the inverted borrow out of bit 3 for subtractions.
- R5: Z is set exactly when the 8-bit result is zero, for every operation that writes Z.
- R6: All four add and subtract operations write C, DC and Z.
- R7: AND, OR and XOR write only Z. C and DC keep their values.
- R8: Rotate right gives {C, operand[7:1]} with new C = operand[0]. Rotate left gives {operand[6:0], C} with new C = operand[7]. Only C is written.
- R9: Nibble swap gives {operand[3:0], operand[7:4]} and writes no flag.
- R10: Load memory byte gives the operand and writes only Z. Load immediate gives the operand and store gives the accumulator; neither writes any flag.
- R11: Reset clears all flags to 0. While `op_valid_i` is low, no write enable is active and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation is executed this cycle |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Memory byte or immediate |
| result_o | output | 8 | Operation result |
| c_next_o | output | 1 | Next carry value |
| dc_next_o | output | 1 | Next half-carry value |
| z_next_o | output | 1 | Next zero value |
| c_we_o | output | 1 | Carry write enable |
| dc_we_o | output | 1 | Half-carry write enable |
| z_we_o | output | 1 | Zero write enable |
| c_q_o | output | 1 | Stored carry flag |
| dc_q_o | output | 1 | Stored half-carry flag |
| z_q_o | output | 1 | Stored zero flag |

## Verification
The add and subtract operations are tried with byte pairs that produce four distinct outcomes: no carry at all, a carry out of bit 3 only, wraparound to zero, and a borrow in one nibble but not the other. This separates the two carry outputs from each other, and separates C from Z. The carry-using operations run once with the stored C at 0 and once at 1, which distinguishes the true-borrow sense from the inverted one. Logic, rotate, swap and move operations are applied while the flags hold values that the operation would flip if it wrote them, so any write to an untouched flag shows up at the flag outputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_RRC  = 4'd7,
        OP_RLC  = 4'd8,
        OP_SWAP = 4'd9,
        OP_LDM  = 4'd10,
        OP_LDI  = 4'd11,
        OP_ST   = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         use_c_i,
    input  logic         c_i,
    output logic [W-1:0] sum_o,
    output logic         c_o,
    output logic         h_o
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic         cin;
    logic [W:0]   full;
    logic [H:0]   low;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        cin   = use_c_i ? c_i : sub_i;
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        low   = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin};
        sum_o = full[W-1:0];
        c_o   = full[W];
        h_o   = low[H];
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    localparam int H = W / 2;

    always_comb begin
        res_o = a_i;
        c_o   = c_i;
        case (op_i)
            OP_AND:  res_o = a_i & m_i;
            OP_OR:   res_o = a_i | m_i;
            OP_XOR:  res_o = a_i ^ m_i;
            OP_RRC: begin
                res_o = {c_i, m_i[W-1:1]};
                c_o   = m_i[0];
            end
            OP_RLC: begin
                res_o = {m_i[W-2:0], c_i};
                c_o   = m_i[W-1];
            end
            OP_SWAP: res_o = {m_i[H-1:0], m_i[W-1:H]};
            OP_LDM,
            OP_LDI:  res_o = m_i;
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    output logic [W-1:0] result_o,
    output logic         c_next_o,
    output logic         dc_next_o,
    output logic         z_next_o,
    output logic         c_we_o,
    output logic         dc_we_o,
    output logic         z_we_o,
    output logic         c_q_o,
    output logic         dc_q_o,
    output logic         z_q_o
);
    alu_op_e      op;
    flags_t       flags_d, flags_q, nxt, we;
    logic         is_arith, is_sub, use_c;
    logic [W-1:0] as_sum, bo_res;
    logic         as_c, as_h, bo_c;

    assign op       = alu_op_e'(op_i);
    assign is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBC);
    assign is_sub   = (op == OP_SUB) || (op == OP_SBC);
    assign use_c    = (op == OP_ADC) || (op == OP_SBC);

    alu8_addsub #(.W(W)) u_addsub (
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .sub_i  (is_sub),
        .use_c_i(use_c),
        .c_i    (flags_q.c),
        .sum_o  (as_sum),
        .c_o    (as_c),
        .h_o    (as_h)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .op_i (op),
        .a_i  (acc_i),
        .m_i  (opnd_i),
        .c_i  (flags_q.c),
        .res_o(bo_res),
        .c_o  (bo_c)
    );

    always_comb begin
        result_o = is_arith ? as_sum : bo_res;
        nxt.c    = is_arith ? as_c : bo_c;
        nxt.dc   = as_h;
        nxt.z    = (result_o == '0);
        we       = '0;
        if (op_valid_i) begin
            case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC: we = '{c: 1'b1, dc: 1'b1, z: 1'b1};
                OP_AND, OP_OR, OP_XOR, OP_LDM:  we = '{c: 1'b0, dc: 1'b0, z: 1'b1};
                OP_RRC, OP_RLC:                 we = '{c: 1'b1, dc: 1'b0, z: 1'b0};
                default:                        we = '0;
            endcase
        end
        flags_d = flags_q;
        if (we.c)  flags_d.c  = nxt.c;
        if (we.dc) flags_d.dc = nxt.dc;
        if (we.z)  flags_d.z  = nxt.z;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign c_next_o  = nxt.c;
    assign dc_next_o = nxt.dc;
    assign z_next_o  = nxt.z;
    assign c_we_o    = we.c;
    assign dc_we_o   = we.dc;
    assign z_we_o    = we.z;
    assign c_q_o     = flags_q.c;
    assign dc_q_o    = flags_q.dc;
    assign z_q_o     = flags_q.z;

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == 4'd0) |=> c_q_o == ((({1'b0, $past(acc_i)} + {1'b0, $past(opnd_i)}) >> W) != 0)); // R2
    AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == 4'd2) |=> c_q_o == ($past(acc_i) >= $past(opnd_i))); // R3
    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && z_we_o) |=> z_q_o == ($past(result_o) == '0)); // R5
    AST_LOGIC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6)) |=> ($stable(c_q_o) && $stable(dc_q_o))); // R7
    AST_SWAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == 4'd9) |=> ($stable(c_q_o) && $stable(dc_q_o) && $stable(z_q_o))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> ($stable(c_q_o) && $stable(dc_q_o) && $stable(z_q_o))); // R11
    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |-> $countones({c_we_o, dc_we_o, z_we_o}) == 0); // R11

endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] acc_i = 8'd0;
    logic [7:0] opnd_i = 8'd0;
    logic [7:0] result_o;
    logic       c_next_o, dc_next_o, z_next_o;
    logic       c_we_o, dc_we_o, z_we_o;
    logic       c_q_o, dc_q_o, z_q_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .result_o(result_o),
        .c_next_o(c_next_o), .dc_next_o(dc_next_o), .z_next_o(z_next_o),
        .c_we_o(c_we_o), .dc_we_o(dc_we_o), .z_we_o(z_we_o),
        .c_q_o(c_q_o), .dc_q_o(dc_q_o), .z_q_o(z_q_o)
    );

    task automatic check_flags(input string tag, input logic [2:0] exp);
        n_tests++;
        if ({c_q_o, dc_q_o, z_q_o} !== exp) begin
            n_fail++;
            $display("FAIL %s flags C/DC/Z actual=%b expected=%b", tag, {c_q_o, dc_q_o, z_q_o}, exp);
        end
    endtask

    task automatic do_op(input string tag, input logic v, input logic [3:0] op,
                         input logic [7:0] a, input logic [7:0] m,
                         input logic [7:0] exp_res, input logic [2:0] exp_flags);
        @(negedge clk);
        op_valid_i = v; op_i = op; acc_i = a; opnd_i = m;
        #1;
        n_tests++;
        if (result_o !== exp_res) begin
            n_fail++;
            $display("FAIL %s result actual=%h expected=%h", tag, result_o, exp_res);
        end
        @(negedge clk);
        op_valid_i = 1'b0;
        check_flags(tag, exp_flags);
    endtask

    task automatic t_reset;
        check_flags("R11 reset", 3'b000);
    endtask

    task automatic t_add;
        do_op("R2 R4 add low carry", 1, 4'd0, 8'h0F, 8'h01, 8'h10, 3'b010);
        do_op("R2 R5 add wrap",      1, 4'd0, 8'hFF, 8'h01, 8'h00, 3'b111);
        do_op("R2 R6 adc C=1",       1, 4'd1, 8'h10, 8'h20, 8'h31, 3'b000);
        do_op("R2 R5 adc C=0",       1, 4'd1, 8'h80, 8'h80, 8'h00, 3'b101);
    endtask

    task automatic t_sub;
        do_op("R3 R4 sub no borrow", 1, 4'd2, 8'h05, 8'h03, 8'h02, 3'b110);
        do_op("R3 R4 sub borrow",    1, 4'd2, 8'h03, 8'h05, 8'hFE, 3'b000);
        do_op("R4 sub nibble borrow",1, 4'd2, 8'h10, 8'h01, 8'h0F, 3'b100);
        do_op("R3 R6 sbc C=1",       1, 4'd3, 8'h07, 8'h07, 8'h00, 3'b111);
        do_op("R3 set C=0",          1, 4'd2, 8'h00, 8'h01, 8'hFF, 3'b000);
        do_op("R3 sbc C=0",          1, 4'd3, 8'h07, 8'h07, 8'hFF, 3'b000);
    endtask

    task automatic t_logic;
        do_op("R2 prep",             1, 4'd0, 8'hFF, 8'h01, 8'h00, 3'b111);
        do_op("R7 and",              1, 4'd4, 8'hF0, 8'h0F, 8'h00, 3'b111);
        do_op("R7 or",               1, 4'd5, 8'hF0, 8'h0F, 8'hFF, 3'b110);
        do_op("R7 xor",              1, 4'd6, 8'hAA, 8'hAA, 8'h00, 3'b111);
    endtask

    task automatic t_rotate;
        do_op("R8 rrc",              1, 4'd7, 8'h00, 8'h02, 8'h81, 3'b011);
        do_op("R8 rlc",              1, 4'd8, 8'h00, 8'h81, 8'h02, 3'b111);
    endtask

    task automatic t_swap;
        do_op("R7 prep or",          1, 4'd5, 8'h01, 8'h00, 8'h01, 3'b110);
        do_op("R9 swap zero",        1, 4'd9, 8'h00, 8'h00, 8'h00, 3'b110);
        do_op("R9 swap",             1, 4'd9, 8'h00, 8'h3C, 8'hC3, 3'b110);
    endtask

    task automatic t_move;
        do_op("R10 ldm zero",        1, 4'd10, 8'h99, 8'h00, 8'h00, 3'b111);
        do_op("R10 ldm nonzero",     1, 4'd10, 8'h00, 8'h42, 8'h42, 3'b110);
        do_op("R10 ldi zero",        1, 4'd11, 8'h33, 8'h00, 8'h00, 3'b110);
        do_op("R10 store",           1, 4'd12, 8'h00, 8'h77, 8'h00, 3'b110);
    endtask

    task automatic t_idle;
        @(negedge clk);
        op_valid_i = 1'b0; op_i = 4'd2; acc_i = 8'h00; opnd_i = 8'h01;
        #1;
        n_tests++;
        if ({c_we_o, dc_we_o, z_we_o} !== 3'b000) begin
            n_fail++;
            $display("FAIL R11 idle write enables actual=%b expected=000", {c_we_o, dc_we_o, z_we_o});
        end
        do_op("R11 idle add",        0, 4'd0, 8'hFF, 8'h01, 8'h00, 3'b110);
    endtask

    task automatic t_undef;
        do_op("R1 undefined op",     1, 4'd14, 8'h5A, 8'h00, 8'h5A, 3'b110);
        do_op("R1 undefined op 15",  1, 4'd15, 8'h00, 8'hFF, 8'h00, 3'b110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_rotate();
        t_swap();
        t_move();
        t_idle();
        t_undef();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule